// File: doc/BRIEF.md
# I2C Transfer Direction and Acknowledge Check Controller

This block is the control and status side of an I2C byte engine. It keeps the transfer direction flag (0 means receive, 1 means transmit), an enable that says whether the acknowledge returned after each transmitted byte is judged, the last judged acknowledge value, and three completion flags. The flags are transmit-buffer-empty, interrupt-pending and ready-for-next-byte. A separate shifter reports three kinds of event as single-cycle pulses: lost arbitration during a master transmission, the first frame received as a slave together with its direction bit, and the end of a transmitted byte together with the sampled acknowledge.

Software uses one 8-bit control/status word. Hardware may change the direction flag by itself. After such a change, software writes to that flag are locked out until software has read the word. This stops an old write from undoing the hardware decision. When acknowledge judging is on, a not-acknowledged byte raises only the interrupt-pending flag. The ready and empty flags stay low, so continuous transfer stops.

Top module: `i2c_xfer_ctl`

## Requirements
- R1: After reset, `csr_rdata` reads 0x00 and `irq` is 0. Direction is receive, judging is off, all flags and the interrupt enable are 0.
- R2: A pulse on `evt_arb_lost` clears the direction flag (`csr_rdata[0]`) to 0 in the next cycle.
- R3: A pulse on `evt_first_frame` with `evt_rw` = 1 sets the direction flag to 1 in the next cycle. With `evt_rw` = 0 it leaves the flag unchanged. If `evt_arb_lost` is also high, arbitration loss takes priority.
- R4: After a hardware change of the direction flag, a write to `csr_wdata[0]` is ignored until a read (`csr_rd`) has been made in an earlier cycle.
- R5: With no lockout pending, or after the unlocking read, a write loads `csr_wdata[0]` into the direction flag. That write also releases the lockout.
- R6: When judging is off (`csr_rdata[1]` = 0), `evt_byte_done` sets empty (bit 3), pending (bit 4) and ready (bit 5) whatever `evt_ack` is. The acknowledge status (bit 2) stays 0.
- R7: When judging is on and `evt_ack` = 0, `evt_byte_done` sets all three flags and leaves bit 2 at 0.
- R8: When judging is on and `evt_ack` = 1, `evt_byte_done` sets only pending and sets bit 2 to 1. Empty and ready keep their old values.
- R9: A write with 0 in bit 3, 4 or 5 clears that flag. A 1 in those bits has no effect. A completion event in the same cycle wins over the clear.
- R10: `irq` is 1 exactly when the pending flag and the interrupt enable (`csr_rdata[6]`, written through `csr_wdata[6]`) are both 1.
- R11: If a hardware direction event and a software write fall in the same cycle, the hardware value is kept and the lockout is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Write strobe for the control/status word |
| csr_wdata | input | 8 | Write data: bit0 direction, bit1 judge enable, bits3-5 flag clears (0 clears), bit6 interrupt enable |
| csr_rd | input | 1 | Read strobe (arms the unlock) |
| csr_rdata | output | 8 | Status word: bit0 direction, bit1 judge enable, bit2 ack status, bit3 empty, bit4 pending, bit5 ready, bit6 interrupt enable |
| evt_arb_lost | input | 1 | Arbitration lost pulse |
| evt_first_frame | input | 1 | Slave first-frame received pulse |
| evt_rw | input | 1 | Direction bit of that first frame |
| evt_byte_done | input | 1 | Byte transmission complete pulse |
| evt_ack | input | 1 | Sampled acknowledge bit with byte completion |
| mode_tx | output | 1 | Direction flag |
| ack_stat | output | 1 | Judged acknowledge status |
| irq | output | 1 | Interrupt request |

## Verification
Byte completion is tried with all four pairs of judge enable and acknowledge, each starting from cleared flags. This separates the pass case, where three flags rise, from the stop case, where only pending rises, and shows that acknowledge status follows the sample only when judging is on. Direction changes are tried as a write with no read, a read then a write, a slave frame with each direction bit, and a write in the same cycle as a hardware event. These cases separate a working lockout from one that is missing, one that never releases, and one that loses the race to software.

// File: rtl/i2c_xfer_ctl.sv
module i2c_xfer_ctl #(
  parameter int CSR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_wr,
  input  logic [CSR_W-1:0] csr_wdata,
  input  logic             csr_rd,
  output logic [CSR_W-1:0] csr_rdata,
  input  logic             evt_arb_lost,
  input  logic             evt_first_frame,
  input  logic             evt_rw,
  input  logic             evt_byte_done,
  input  logic             evt_ack,
  output logic             mode_tx,
  output logic             ack_stat,
  output logic             irq
);
  localparam int B_MODE = 0, B_JUDGE = 1, B_ACK = 2, B_EMPTY = 3,
                 B_PEND = 4, B_RDY = 5, B_IEN = 6;

  logic mode_q, judge_q, ack_q, empty_q, pend_q, rdy_q, ien_q;
  logic lock_q, seen_q;

  wire hw_clr = evt_arb_lost;
  wire hw_set = evt_first_frame & evt_rw & ~evt_arb_lost;
  wire hw_evt = hw_clr | hw_set;
  wire sw_ok  = csr_wr & (~lock_q | seen_q);
  wire pass   = ~(judge_q & evt_ack);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      lock_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      if (hw_clr)      mode_q <= 1'b0;
      else if (hw_set) mode_q <= 1'b1;
      else if (sw_ok)  mode_q <= csr_wdata[B_MODE];

      if (hw_evt) begin
        lock_q <= 1'b1;
        seen_q <= 1'b0;
      end else if (lock_q) begin
        if (csr_wr && seen_q) begin
          lock_q <= 1'b0;
          seen_q <= 1'b0;
        end else if (csr_rd) begin
          seen_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      judge_q <= 1'b0;
      ien_q   <= 1'b0;
      ack_q   <= 1'b0;
      empty_q <= 1'b0;
      pend_q  <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      if (csr_wr) begin
        judge_q <= csr_wdata[B_JUDGE];
        ien_q   <= csr_wdata[B_IEN];
      end

      if (evt_byte_done)                     ack_q <= judge_q & evt_ack;
      else if (csr_wr && !csr_wdata[B_JUDGE]) ack_q <= 1'b0;

      if (evt_byte_done && pass)             empty_q <= 1'b1;
      else if (csr_wr && !csr_wdata[B_EMPTY]) empty_q <= 1'b0;

      if (evt_byte_done)                     pend_q <= 1'b1;
      else if (csr_wr && !csr_wdata[B_PEND])  pend_q <= 1'b0;

      if (evt_byte_done && pass)             rdy_q <= 1'b1;
      else if (csr_wr && !csr_wdata[B_RDY])   rdy_q <= 1'b0;
    end
  end

  always_comb begin
    csr_rdata          = '0;
    csr_rdata[B_MODE]  = mode_q;
    csr_rdata[B_JUDGE] = judge_q;
    csr_rdata[B_ACK]   = ack_q;
    csr_rdata[B_EMPTY] = empty_q;
    csr_rdata[B_PEND]  = pend_q;
    csr_rdata[B_RDY]   = rdy_q;
    csr_rdata[B_IEN]   = ien_q;
  end

  assign mode_tx  = mode_q;
  assign ack_stat = ack_q;
  assign irq      = pend_q & ien_q;

  AST_ARB_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_arb_lost |=> !mode_tx); // R2
  AST_RW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_first_frame && evt_rw && !evt_arb_lost) |=> mode_tx); // R3
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !seen_q && csr_wr && !hw_evt) |=> $stable(mode_tx)); // R4
  AST_NOJUDGE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_byte_done && !csr_rdata[B_JUDGE]) |=> (!ack_stat && csr_rdata[B_EMPTY] && csr_rdata[B_PEND] && csr_rdata[B_RDY])); // R6
  AST_NACK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_byte_done && csr_rdata[B_JUDGE] && evt_ack) |=> (ack_stat && csr_rdata[B_PEND] && $stable(csr_rdata[B_EMPTY]) && $stable(csr_rdata[B_RDY]))); // R8
  AST_HW_ARMS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    hw_evt |=> (lock_q && !seen_q)); // R11
endmodule

// File: tb/i2c_xfer_ctl_tb.sv
module i2c_xfer_ctl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic csr_wr = 0, csr_rd = 0;
  logic [7:0] csr_wdata = 0;
  logic [7:0] csr_rdata;
  logic evt_arb_lost = 0, evt_first_frame = 0, evt_rw = 0, evt_byte_done = 0, evt_ack = 0;
  logic mode_tx, ack_stat, irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_xfer_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rd(csr_rd), .csr_rdata(csr_rdata), .evt_arb_lost(evt_arb_lost),
    .evt_first_frame(evt_first_frame), .evt_rw(evt_rw),
    .evt_byte_done(evt_byte_done), .evt_ack(evt_ack),
    .mode_tx(mode_tx), .ack_stat(ack_stat), .irq(irq));

  // {judge, ack, exp_ack_stat, exp_empty, exp_pend, exp_rdy}
  localparam logic [5:0] VEC [4] = '{
    6'b00_0111,   // R6
    6'b01_0111,   // R6
    6'b10_0111,   // R7
    6'b11_1010    // R8
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] wd(input logic mode, input logic judge, input logic ien, input logic clr);
    return {1'b0, ien, ~clr, ~clr, ~clr, 1'b0, judge, mode};
  endfunction

  task automatic wr(input logic [7:0] d);
    csr_wr = 1; csr_wdata = d;
    @(negedge clk);
    csr_wr = 0;
  endtask

  task automatic rd();
    csr_rd = 1;
    @(negedge clk);
    csr_rd = 0;
  endtask

  task automatic byte_done(input logic a);
    evt_byte_done = 1; evt_ack = a;
    @(negedge clk);
    evt_byte_done = 0; evt_ack = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 status", csr_rdata, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    for (int i = 0; i < 4; i++) begin
      wr(wd(0, VEC[i][5], 0, 1));
      byte_done(VEC[i][4]);
      chk(VEC[i][5] ? (VEC[i][4] ? "R8 flags" : "R7 flags") : "R6 flags",
          {4'b0, csr_rdata[5], csr_rdata[4], csr_rdata[3], csr_rdata[2]},
          {4'b0, VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]});
    end

    wr(wd(0, 0, 0, 1));
    byte_done(0);
    wr(wd(0, 0, 0, 0));
    chk("R9 write ones keep flags", csr_rdata, 8'h38);
    wr(8'h28);
    chk("R9 clear pending only", csr_rdata, 8'h28);
    chk("R10 irq off when pending 0", {7'b0, irq}, 8'h00);
    byte_done(0);
    chk("R10 irq off when enable 0", {7'b0, irq}, 8'h00);
    wr(wd(0, 0, 1, 0));
    chk("R10 irq on", {7'b0, irq}, 8'h01);
    wr(wd(0, 0, 0, 1));
    evt_byte_done = 1; csr_wr = 1; csr_wdata = wd(0, 0, 0, 1);
    @(negedge clk);
    evt_byte_done = 0; csr_wr = 0;
    chk("R9 event beats clear", csr_rdata, 8'h38);
    wr(wd(0, 0, 0, 1));

    wr(wd(1, 0, 0, 1));
    chk("R5 unlocked write 1", {7'b0, mode_tx}, 8'h01);
    wr(wd(0, 0, 0, 1));
    chk("R5 unlocked write 0", {7'b0, mode_tx}, 8'h00);
    wr(wd(1, 0, 0, 1));

    evt_arb_lost = 1;
    @(negedge clk);
    evt_arb_lost = 0;
    chk("R2 arb lost", {7'b0, mode_tx}, 8'h00);
    wr(wd(1, 0, 0, 1));
    chk("R4 write without read", {7'b0, mode_tx}, 8'h00);
    rd();
    wr(wd(1, 0, 0, 1));
    chk("R5 write after read", {7'b0, mode_tx}, 8'h01);
    wr(wd(0, 0, 0, 1));
    chk("R5 lock released", {7'b0, mode_tx}, 8'h00);

    evt_first_frame = 1; evt_rw = 0;
    @(negedge clk);
    evt_first_frame = 0;
    chk("R3 rw 0 keeps receive", {7'b0, mode_tx}, 8'h00);
    evt_first_frame = 1; evt_rw = 1;
    @(negedge clk);
    evt_first_frame = 0; evt_rw = 0;
    chk("R3 rw 1 sets transmit", {7'b0, mode_tx}, 8'h01);
    wr(wd(0, 0, 0, 1));
    chk("R4 clear blocked", {7'b0, mode_tx}, 8'h01);
    rd();
    wr(wd(0, 0, 0, 1));
    chk("R5 clear after read", {7'b0, mode_tx}, 8'h00);

    evt_first_frame = 1; evt_rw = 1; evt_arb_lost = 1;
    @(negedge clk);
    evt_first_frame = 0; evt_rw = 0; evt_arb_lost = 0;
    chk("R3 arb loss priority", {7'b0, mode_tx}, 8'h00);
    rd();
    wr(wd(0, 0, 0, 1));

    evt_first_frame = 1; evt_rw = 1; csr_wr = 1; csr_wdata = wd(0, 0, 0, 1);
    @(negedge clk);
    evt_first_frame = 0; evt_rw = 0; csr_wr = 0;
    chk("R11 hardware wins", {7'b0, mode_tx}, 8'h01);
    wr(wd(0, 0, 0, 1));
    chk("R11 lock armed", {7'b0, mode_tx}, 8'h01);

    wr(wd(1, 1, 0, 1));
    byte_done(1);
    wr(wd(1, 0, 0, 1));
    chk("R6 ack status cleared with judge off", {7'b0, ack_stat}, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule